// File: doc/BRIEF.md
# Packet Radio Receive Controller with Bank Guard

This block is the receive-side controller of a packet radio baseband. A host loads an 8-bit mode register over a byte-wide write port. The register turns reception on and off, arms a signal-loss abort, allows full banks to be overwritten, and picks which bank's status is shown to the host. The demodulator sends frame-start, frame-end, signal-present and byte-valid strobes. From these, a three-state machine (idle, waiting for a frame, receiving) decides when bytes may go to the receive RAM.

The receive RAM has two banks used in ping-pong order. Each bank has a full flag. A good frame end sets the flag, and the host clears it with a one-cycle clear strobe. A byte write to a full bank is suppressed unless overwrite is allowed. If the signal drops mid-frame while the abort is armed, the frame is dropped and a level-loss interrupt is raised. No completion interrupt follows, and no full flag changes. The machine then passes through idle and returns by itself to waiting for the next frame.

Top module: `rxg_top`

## Requirements
- R1: The mode register clears to 0x00 on reset and takes a whole 8-bit value on each host write, visible on `mode_rd` from the next cycle. Field positions: bit 0 receive enable, bit 1 level-abort enable, bit 2 overwrite enable, bit 3 status bank select, bits 7:4 stored only.
- R2: While receive enable is 0, `ram_we` stays 0 and a frame start leaves the state in idle. State code on `rx_state`: 0 idle, 1 waiting, 2 receiving.
- R3: With level-abort enabled, a cycle in the receiving state where `sig_present` is 0 writes no byte. The machine goes to idle, and `irq_lvl` pulses the next cycle if `lvl_ie` is 1.
- R4: An aborted frame never gives `irq_done`, leaves every full flag unchanged, and does not advance the bank order.
- R5: After an abort the state is idle for exactly one cycle and then waiting, with receive enable still 1, so a new frame start is accepted.
- R6: With level-abort disabled, loss of signal is ignored: bytes are still written and the frame completes normally.
- R7: A byte-valid in the receiving state writes the current bank (one bit of `ram_we`, bit i for bank i) unless that bank is full and overwrite is 0, in which case nothing is written.
- R8: With overwrite set to 1, bytes are written to the current bank even when its full flag is 1.
- R9: A frame end in the receiving state sets the current bank's full flag, returns the state to waiting and moves the next frame to the other bank. `irq_done` pulses the next cycle.
- R10: A 1 on `bank_clr[i]` clears bank i's full flag; if a frame ends on that bank in the same cycle, the set wins.
- R11: Each interrupt is a single-cycle pulse and stays 0 when its enable input (`done_ie`, `lvl_ie`) is 0.
- R12: `stat_full` shows the full flag of the bank named by the status bank select bit.
- R13: Clearing receive enable during a frame sends the machine to idle with no interrupt and no full flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the mode register |
| host_wdata | input | 8 | Mode register write data |
| bank_clr | input | 2 | Per-bank full flag clear strobes |
| done_ie | input | 1 | Completion interrupt enable |
| lvl_ie | input | 1 | Level-loss interrupt enable |
| frame_start | input | 1 | Demodulator frame start strobe |
| frame_end | input | 1 | Demodulator frame end strobe |
| sig_present | input | 1 | Demodulator signal present level |
| byte_valid | input | 1 | Demodulator received byte strobe |
| mode_rd | output | 8 | Mode register contents |
| rx_state | output | 2 | Receive state code |
| ram_we | output | 2 | Per-bank receive RAM write enable |
| bank_full | output | 2 | Per-bank full flags |
| stat_full | output | 1 | Full flag of the host-selected bank |
| irq_done | output | 1 | Frame completion interrupt pulse |
| irq_lvl | output | 1 | Level-loss abort interrupt pulse |

## Verification
The assertions check on every cycle that at most one bank is written, that a full bank is never written without overwrite, and that nothing is written while reception is off. They also check that the two interrupts never coincide, that each is one cycle long, and that an abort lands in idle with the full flags untouched. The ping-pong order across frames, the idle-then-waiting return after an abort, the set-beats-clear priority, the interrupt-enable gating and the status bank readback depend on sequences of frames, so only the bench scenarios show them.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
    localparam int MODE_W = 8;

    typedef enum logic [1:0] {
        RXS_IDLE = 2'd0,
        RXS_WAIT = 2'd1,
        RXS_RECV = 2'd2
    } rxs_e;

    typedef struct packed {
        logic [3:0] spare;
        logic       bank_sel;
        logic       ovw_en;
        logic       lvl_en;
        logic       rx_en;
    } mode_t;

    function automatic logic lvl_abort(input rxs_e st, input mode_t m, input logic sig);
        return (st == RXS_RECV) && m.rx_en && m.lvl_en && !sig;
    endfunction
endpackage

// File: rtl/rxg_mode_reg.sv
module rxg_mode_reg
    import rxg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    output mode_t             mode_q
);
    always_ff @(posedge clk) begin
        if (rst)        mode_q <= '0;
        else if (wr_en) mode_q <= mode_t'(wr_data);
    end
endmodule

// File: rtl/rxg_fsm.sv
module rxg_fsm
    import rxg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_t mode,
    input  logic  frame_start,
    input  logic  frame_end,
    input  logic  sig_present,
    output rxs_e  state,
    output logic  recv_active,
    output logic  good_end,
    output logic  abort
);
    rxs_e state_n;

    always_comb begin
        abort       = lvl_abort(state, mode, sig_present);
        recv_active = (state == RXS_RECV) && mode.rx_en && !abort;
        good_end    = recv_active && frame_end;
        state_n     = state;
        unique case (state)
            RXS_IDLE: if (mode.rx_en) state_n = RXS_WAIT;
            RXS_WAIT: begin
                if (!mode.rx_en)      state_n = RXS_IDLE;
                else if (frame_start) state_n = RXS_RECV;
            end
            RXS_RECV: begin
                if (!mode.rx_en || abort) state_n = RXS_IDLE;
                else if (frame_end)       state_n = RXS_WAIT;
            end
            default: state_n = RXS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= RXS_IDLE;
        else     state <= state_n;
    end
endmodule

// File: rtl/rxg_bank_gate.sv
module rxg_bank_gate #(
    parameter int NBANK = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_valid,
    input  logic             recv_active,
    input  logic             good_end,
    input  logic             ovw_en,
    input  logic             sel_bit,
    input  logic [NBANK-1:0] bank_clr,
    output logic [NBANK-1:0] ram_we,
    output logic [NBANK-1:0] bank_full,
    output logic             stat_full
);
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam logic [BW-1:0] LAST = BW'(NBANK - 1);

    logic [BW-1:0] cur;
    logic [BW-1:0] sel_idx;

    assign sel_idx   = BW'(sel_bit);
    assign stat_full = bank_full[sel_idx];

    always_ff @(posedge clk) begin
        if (rst)           cur <= '0;
        else if (good_end) cur <= (cur == LAST) ? '0 : cur + 1'b1;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit       = (cur == BW'(b));
        assign ram_we[b] = recv_active && byte_valid && hit && (!bank_full[b] || ovw_en);

        always_ff @(posedge clk) begin
            if (rst)                  bank_full[b] <= 1'b0;
            else if (good_end && hit) bank_full[b] <= 1'b1;
            else if (bank_clr[b])     bank_full[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/rxg_top.sv
module rxg_top
    import rxg_pkg::*;
#(
    parameter int NBANK = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [7:0]       host_wdata,
    input  logic [NBANK-1:0] bank_clr,
    input  logic             done_ie,
    input  logic             lvl_ie,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic             sig_present,
    input  logic             byte_valid,
    output logic [7:0]       mode_rd,
    output logic [1:0]       rx_state,
    output logic [NBANK-1:0] ram_we,
    output logic [NBANK-1:0] bank_full,
    output logic             stat_full,
    output logic             irq_done,
    output logic             irq_lvl
);
    mode_t mode;
    rxs_e  state;
    logic  recv_active, good_end, abort;

    rxg_mode_reg u_mode (
        .clk(clk), .rst(rst), .wr_en(host_we), .wr_data(host_wdata), .mode_q(mode)
    );

    rxg_fsm u_fsm (
        .clk(clk), .rst(rst), .mode(mode),
        .frame_start(frame_start), .frame_end(frame_end), .sig_present(sig_present),
        .state(state), .recv_active(recv_active), .good_end(good_end), .abort(abort)
    );

    rxg_bank_gate #(.NBANK(NBANK)) u_gate (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .recv_active(recv_active),
        .good_end(good_end), .ovw_en(mode.ovw_en), .sel_bit(mode.bank_sel),
        .bank_clr(bank_clr), .ram_we(ram_we), .bank_full(bank_full), .stat_full(stat_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_done <= 1'b0;
            irq_lvl  <= 1'b0;
        end else begin
            irq_done <= good_end && done_ie;
            irq_lvl  <= abort && lvl_ie;
        end
    end

    assign mode_rd  = mode;
    assign rx_state = state;
endmodule

// File: rtl/rxg_checker.sv
module rxg_checker
    import rxg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [7:0] mode_rd,
    input logic [1:0] rx_state,
    input logic [1:0] ram_we,
    input logic [1:0] bank_full,
    input logic [1:0] bank_clr,
    input logic       irq_done,
    input logic       irq_lvl
);
    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ram_we)); // R7
    AST_WE_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !mode_rd[0] |-> ram_we == 2'b00); // R2
    AST_FULL_GUARD_B0: assert property (@(posedge clk) disable iff (rst)
        ram_we[0] |-> (!bank_full[0] || mode_rd[2])); // R8
    AST_FULL_GUARD_B1: assert property (@(posedge clk) disable iff (rst)
        ram_we[1] |-> (!bank_full[1] || mode_rd[2])); // R7
    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(irq_done && irq_lvl)); // R4
    AST_LVL_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_lvl |=> !irq_lvl); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_done |=> !irq_done); // R11
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        irq_lvl |-> rx_state == 2'(RXS_IDLE)); // R5
    AST_ABORT_KEEPS_FULL: assert property (@(posedge clk) disable iff (rst)
        (irq_lvl && $past(bank_clr) == 2'b00) |-> bank_full == $past(bank_full)); // R4
    AST_DONE_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
        irq_done |-> (bank_full != 2'b00)); // R9
endmodule

bind rxg_top rxg_checker u_rxg_checker (
    .clk(clk), .rst(rst), .mode_rd(mode_rd), .rx_state(rx_state), .ram_we(ram_we),
    .bank_full(bank_full), .bank_clr(bank_clr), .irq_done(irq_done), .irq_lvl(irq_lvl)
);

// File: tb/rxg_top_bench.sv
module rxg_top_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       host_we;
    logic [7:0] host_wdata;
    logic [1:0] bank_clr;
    logic       done_ie, lvl_ie;
    logic       frame_start, frame_end, sig_present, byte_valid;
    logic [7:0] mode_rd;
    logic [1:0] rx_state, ram_we, bank_full;
    logic       stat_full, irq_done, irq_lvl;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    rxg_top u_rxg_top (
        .clk(clk), .rst(rst), .host_we(host_we), .host_wdata(host_wdata),
        .bank_clr(bank_clr), .done_ie(done_ie), .lvl_ie(lvl_ie),
        .frame_start(frame_start), .frame_end(frame_end), .sig_present(sig_present),
        .byte_valid(byte_valid), .mode_rd(mode_rd), .rx_state(rx_state),
        .ram_we(ram_we), .bank_full(bank_full), .stat_full(stat_full),
        .irq_done(irq_done), .irq_lvl(irq_lvl)
    );

    // row: [9]start [8]end [7]sig [6]byte [5:4]we [3:2]state after edge [1]irq_done [0]irq_lvl
    localparam int NROW = 15;
    localparam logic [9:0] ROWS [0:NROW-1] = '{
        10'b1011_00_10_00, 10'b0011_01_10_00, 10'b0010_00_10_00, 10'b0111_01_01_10,
        10'b0010_00_01_00, 10'b1010_00_10_00, 10'b0011_10_10_00, 10'b0001_00_00_01,
        10'b0010_00_01_00, 10'b1010_00_10_00, 10'b0011_10_10_00, 10'b0110_00_01_10,
        10'b1010_00_10_00, 10'b0011_00_10_00, 10'b0110_00_01_10
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        host_we     = 1'b0;
        bank_clr    = 2'b00;
        frame_start = 1'b0;
        frame_end   = 1'b0;
        byte_valid  = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] v);
        host_we    = 1'b1;
        host_wdata = v;
        tick();
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; host_we = 1'b0; host_wdata = '0; bank_clr = '0;
        done_ie = 1'b1; lvl_ie = 1'b1;
        frame_start = 1'b0; frame_end = 1'b0; sig_present = 1'b1; byte_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset mode", mode_rd, 8'h00);
        chk("R2 reset state", 8'(rx_state), 8'd0);
        chk("R9 reset full", 8'(bank_full), 8'd0);
        chk("R11 reset irqs", {6'd0, irq_done, irq_lvl}, 8'd0);

        host_write(8'hA4);
        chk("R1 full byte write", mode_rd, 8'hA4);
        chk("R2 idle while disabled", 8'(rx_state), 8'd0);
        frame_start = 1'b1; byte_valid = 1'b1;
        #1 chk("R2 no write while disabled", 8'(ram_we), 8'd0);
        tick();
        chk("R2 start ignored while disabled", 8'(rx_state), 8'd0);

        host_write(8'h03);
        tick();
        chk("R5 enable reaches waiting", 8'(rx_state), 8'd1);

        for (int i = 0; i < NROW; i++) begin
            frame_start = ROWS[i][9];
            frame_end   = ROWS[i][8];
            sig_present = ROWS[i][7];
            byte_valid  = ROWS[i][6];
            #1 chk($sformatf("R7 row %0d write enable", i), 8'(ram_we), 8'(ROWS[i][5:4]));
            tick();
            sig_present = 1'b1;
            chk($sformatf("R5 row %0d state", i), 8'(rx_state), 8'(ROWS[i][3:2]));
            chk($sformatf("R9 row %0d irq_done", i), 8'(irq_done), 8'(ROWS[i][1]));
            chk($sformatf("R3 row %0d irq_lvl", i), 8'(irq_lvl), 8'(ROWS[i][0]));
        end
        chk("R4 R9 full after ping-pong", 8'(bank_full), 8'b11);
        chk("R12 status bank0", 8'(stat_full), 8'd1);

        bank_clr = 2'b01;
        tick();
        chk("R10 clear bank0", 8'(bank_full), 8'b10);
        chk("R12 status bank0 cleared", 8'(stat_full), 8'd0);
        host_write(8'h0B);
        chk("R12 status bank1", 8'(stat_full), 8'd1);

        // overwrite: next frame goes to bank1, which is full
        host_write(8'h07);
        frame_start = 1'b1; tick();
        byte_valid = 1'b1;
        #1 chk("R8 overwrite into full bank1", 8'(ram_we), 8'b10);
        frame_end = 1'b1; byte_valid = 1'b0; tick();
        chk("R9 overwrite frame done", 8'(irq_done), 8'd1);

        // level abort disabled: signal loss ignored, frame goes to bank0
        host_write(8'h05);
        frame_start = 1'b1; tick();
        sig_present = 1'b0; byte_valid = 1'b1;
        #1 chk("R6 write despite signal loss", 8'(ram_we), 8'b01);
        tick();
        chk("R6 still receiving", 8'(rx_state), 8'd2);
        frame_end = 1'b1; tick();
        sig_present = 1'b1;
        chk("R6 completion", 8'(irq_done), 8'd1);
        chk("R9 bank0 full again", 8'(bank_full), 8'b11);

        // interrupt enable gating
        done_ie = 1'b0;
        frame_start = 1'b1; tick();
        frame_end = 1'b1; tick();
        chk("R11 done masked", 8'(irq_done), 8'd0);
        chk("R11 state waiting", 8'(rx_state), 8'd1);
        done_ie = 1'b1;
        host_write(8'h07);
        lvl_ie = 1'b0;
        frame_start = 1'b1; tick();
        sig_present = 1'b0; tick();
        sig_present = 1'b1;
        chk("R11 lvl masked", 8'(irq_lvl), 8'd0);
        chk("R3 abort to idle", 8'(rx_state), 8'd0);
        chk("R4 abort keeps full", 8'(bank_full), 8'b11);
        tick();
        chk("R5 back to waiting", 8'(rx_state), 8'd1);
        lvl_ie = 1'b1;

        // receive enable dropped mid-frame
        frame_start = 1'b1; tick();
        host_write(8'h06);
        chk("R13 still receiving one cycle", 8'(rx_state), 8'd2);
        byte_valid = 1'b1;
        #1 chk("R2 no write after disable", 8'(ram_we), 8'd0);
        tick();
        chk("R13 idle after disable", 8'(rx_state), 8'd0);
        chk("R13 no irq", {6'd0, irq_done, irq_lvl}, 8'd0);
        frame_start = 1'b1; tick();
        chk("R2 start ignored", 8'(rx_state), 8'd0);

        // set wins over clear
        host_write(8'h07);
        tick();
        bank_clr = 2'b11; tick();
        chk("R10 clear both", 8'(bank_full), 8'b00);
        frame_start = 1'b1; tick();
        frame_end = 1'b1; bank_clr = 2'b11; tick();
        chk("R10 set beats clear", 8'($countones(bank_full)), 8'd1);

        finish_run();
    end
endmodule